// File: doc/BRIEF.md
# Three-Level Clamped Leg Balancer and Gate Driver

This block sits between a three-phase modulator and the gate drivers of a three-level neutral-point-clamped converter. On each modulator strobe it takes the requested per-phase levels (0, 1 or 2), the sign of the split-capacitor imbalance and the direction of each phase current. When the requested vector has a twin that gives the same line-to-line voltages, it chooses whichever of the two pushes the capacitor voltages back toward equality. The chosen vector is held in a register until the next strobe.

Each phase level is decoded into four transistor commands so that exactly two adjacent devices of a leg conduct. The top pair gives the positive rail, the bottom pair gives the negative rail, and the inner pair clamps the output to the capacitor midpoint. Every gate then passes through a delay stage. A turn-on waits a programmable number of clock cycles, and a turn-off takes effect at once. Because of this, the two devices of a complementary pair are both off for that many cycles around every change.

Top module: `npc_state_balancer`

## Requirements
- R1: While `rst_n` is low, `sw_state` reads 0 and every bit of `gate` is 0.
- R2: Phase p owns `gate[4p+3:4p]`. Bit 3 is the outer upper device (U1), bit 2 the inner upper (U2), bit 1 the inner lower (L2) and bit 0 the outer lower (L1). Once settled, level 0 gives 4'b0011, level 1 gives 4'b0110 and level 2 gives 4'b1100. An input code of 3 is treated as level 2.
- R3: `sw_state` is loaded only on a clock edge where `dem_vld` is 1. Changes on the other inputs with `dem_vld` low leave `sw_state` and `gate` unchanged.
- R4: A vector with one phase at level 0 and another at level 2 has no twin and is stored unchanged. Phase p sits at bits `[2p+1:2p]` of `dem_state` and `sw_state`, and at bit p of `cur_pos`.
- R5: A vector with every level at most 1, or with every level at least 1, is redundant. Its low twin has every level at most 1 (for all-ones the low twin is 1,1,1), and its high twin is the low twin plus one on every phase. The phases at level 1 in the low twin form the vote group. If the vote group holds as many positive-current phases (`cur_pos` bit 1) as negative ones, the requested vector is kept. This tie case includes the empty group of 0,0,0.
- R6: Otherwise, let net-positive be true when the positive currents outnumber the negative ones in the vote group. `upper_high` is 1 when the upper capacitor holds the higher voltage. The high twin is chosen when net-positive equals `upper_high`; otherwise the low twin is chosen.
- R7: A command change takes effect on `gate` as follows. A device that turns off goes low one clock after the capturing edge. A device that turns on goes high `dead_cyc`+1 clocks after that edge. The pairs (U1,L2) and (U2,L1) are never on together.
- R8: With `dead_cyc` = 0, turn-off and turn-on both land on the clock after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dem_vld | input | 1 | Modulator strobe; captures a new vector |
| dem_state | input | 6 | Requested levels, 2 bits per phase |
| upper_high | input | 1 | 1 when the upper capacitor voltage exceeds the lower |
| cur_pos | input | 3 | Per-phase current sign, 1 = positive |
| dead_cyc | input | 4 | Turn-on delay in clock cycles |
| sw_state | output | 6 | Chosen levels, 2 bits per phase |
| gate | output | 12 | Transistor commands, 4 per phase |

## Verification
The bench covers both sides of the twin choice for each imbalance sign. It also checks the all-ones and all-twos vectors, where all three phases vote, and the tie and all-zero cases that must pass through untouched. A design that swapped the twins, inverted the imbalance polarity or counted the wrong group would store a vector shifted one level from the expected one. Timing is sampled cycle by cycle around a 0-to-2 phase step, with the delay set to 3 and then to 0. A stage that delayed turn-off, or counted one cycle too few or too many, would show overlapping or late gate bits. An input change without a strobe, and a code of 3, are checked at the ports, where a leaky enable or a bad clamp would show up as a wrong level.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_LO  = 2'd0;
  localparam lvl_t LVL_MID = 2'd1;
  localparam lvl_t LVL_HI  = 2'd2;
  localparam int   LEG_SW  = 4;
  localparam logic [LEG_SW-1:0] PAT_LO  = 4'b0011;
  localparam logic [LEG_SW-1:0] PAT_MID = 4'b0110;
  localparam logic [LEG_SW-1:0] PAT_HI  = 4'b1100;
endpackage

// File: rtl/nr_vec_select.sv
module nr_vec_select
  import npc_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic [2*NPH-1:0] want,
  input  logic             upper_high,
  input  logic [NPH-1:0]   cur_pos,
  output logic [2*NPH-1:0] pick
);
  lvl_t           w   [NPH];
  lvl_t           lo  [NPH];
  lvl_t           hi  [NPH];
  logic [NPH-1:0] grp;
  logic           all_le1, all_ge1, redundant, take_hi;
  int             npos, nneg;

  always_comb begin
    all_le1 = 1'b1;
    all_ge1 = 1'b1;
    for (int p = 0; p < NPH; p++) begin
      w[p] = (want[2*p +: 2] == 2'd3) ? LVL_HI : want[2*p +: 2];
      if (w[p] > LVL_MID) all_le1 = 1'b0;
      if (w[p] < LVL_MID) all_ge1 = 1'b0;
    end
    redundant = all_le1 | all_ge1;
    for (int p = 0; p < NPH; p++) begin
      lo[p]  = all_le1 ? w[p] : w[p] - 2'd1;
      hi[p]  = lo[p] + 2'd1;
      grp[p] = (lo[p] == LVL_MID);
    end
    npos    = $countones(grp & cur_pos);
    nneg    = $countones(grp & ~cur_pos);
    take_hi = ((npos > nneg) == upper_high);
    for (int p = 0; p < NPH; p++) begin
      if (!redundant || (npos == nneg)) pick[2*p +: 2] = w[p];
      else if (take_hi)                 pick[2*p +: 2] = hi[p];
      else                              pick[2*p +: 2] = lo[p];
    end
  end
endmodule

// File: rtl/nr_leg_decode.sv
module nr_leg_decode
  import npc_pkg::*;
(
  input  lvl_t              lvl,
  output logic [LEG_SW-1:0] on
);
  always_comb begin
    case (lvl)
      LVL_LO:  on = PAT_LO;
      LVL_MID: on = PAT_MID;
      default: on = PAT_HI;
    endcase
  end
endmodule

// File: rtl/nr_dead_time.sv
module nr_dead_time #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd,
  input  logic [CW-1:0] dead,
  output logic          g
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          g_q, g_d;

  always_comb begin
    cnt_d = cnt_q;
    g_d   = g_q;
    if (!cmd) begin
      cnt_d = '0;
      g_d   = 1'b0;
    end else if (cnt_q >= dead) begin
      g_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      g_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      g_q   <= g_d;
    end
  end

  assign g = g_q;

  // R7
  rise_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(g_q) |-> cmd);
  // R7
  fall_next_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> !g_q);
endmodule

// File: rtl/npc_state_balancer.sv
module npc_state_balancer
  import npc_pkg::*;
#(
  parameter int NPH = 3,
  parameter int DCW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dem_vld,
  input  logic [2*NPH-1:0]    dem_state,
  input  logic                upper_high,
  input  logic [NPH-1:0]      cur_pos,
  input  logic [DCW-1:0]      dead_cyc,
  output logic [2*NPH-1:0]    sw_state,
  output logic [LEG_SW*NPH-1:0] gate
);
  localparam int NGATE = LEG_SW * NPH;

  logic [2*NPH-1:0] pick, st_q, st_d;
  logic [NGATE-1:0] cmd;

  nr_vec_select #(.NPH(NPH)) u_sel (
    .want(dem_state), .upper_high(upper_high), .cur_pos(cur_pos), .pick(pick)
  );

  always_comb begin
    st_d = st_q;
    if (dem_vld) st_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign sw_state = st_q;

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    nr_leg_decode u_dec (
      .lvl(st_q[2*p +: 2]), .on(cmd[LEG_SW*p +: LEG_SW])
    );
    // R7
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[LEG_SW*p+3] && gate[LEG_SW*p+1]) && !(gate[LEG_SW*p+2] && gate[LEG_SW*p]));
    // R2
    leg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate[LEG_SW*p +: LEG_SW]) <= 2);
    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_state[2*p +: 2] != 2'd3);
  end

  for (genvar k = 0; k < NGATE; k++) begin : g_dt
    nr_dead_time #(.CW(DCW)) u_dt (
      .clk(clk), .rst_n(rst_n), .cmd(cmd[k]), .dead(dead_cyc), .g(gate[k])
    );
  end

  // R3
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dem_vld |=> $stable(sw_state));
endmodule

// File: tb/sim_npc_state_balancer.sv
module sim_npc_state_balancer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dem_vld;
  logic [5:0]  dem_state;
  logic        upper_high;
  logic [2:0]  cur_pos;
  logic [3:0]  dead_cyc;
  logic [5:0]  sw_state;
  logic [11:0] gate;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  npc_state_balancer u0 (
    .clk(clk), .rst_n(rst_n), .dem_vld(dem_vld), .dem_state(dem_state),
    .upper_high(upper_high), .cur_pos(cur_pos), .dead_cyc(dead_cyc),
    .sw_state(sw_state), .gate(gate)
  );

  function automatic logic [5:0] pk(input int a, input int b, input int c);
    return {c[1:0], b[1:0], a[1:0]};
  endfunction

  function automatic logic [3:0] leg(input int lv);
    if (lv == 0) return 4'b0011;
    if (lv == 1) return 4'b0110;
    return 4'b1100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [5:0] v, input logic up, input logic [2:0] cp);
    @(negedge clk);
    dem_state = v; upper_high = up; cur_pos = cp; dem_vld = 1'b1;
    @(negedge clk);
    dem_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (int'(dead_cyc) + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dem_vld = 1'b0; dem_state = '0; upper_high = 1'b0;
    cur_pos = '0; dead_cyc = 4'd2;
    repeat (3) @(negedge clk);
    chk(sw_state == 6'd0, "R1 state", sw_state, 0);
    chk(gate == 12'd0, "R1 gate", gate, 0);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_decode();
    strobe(pk(0, 1, 2), 1'b1, 3'b111);
    chk(sw_state == pk(0, 1, 2), "R4 pass", sw_state, pk(0, 1, 2));
    settle();
    chk(gate == {leg(2), leg(1), leg(0)}, "R2 decode", gate, {leg(2), leg(1), leg(0)});
    strobe(pk(3, 0, 1), 1'b0, 3'b000);
    chk(sw_state == pk(2, 0, 1), "R2 code3", sw_state, pk(2, 0, 1));
    settle();
    chk(gate[3:0] == 4'b1100, "R2 code3 gate", gate[3:0], 4'b1100);
  endtask

  task automatic t_hold();
    logic [11:0] g0;
    g0 = gate;
    @(negedge clk);
    dem_state = pk(1, 1, 1); cur_pos = 3'b101; upper_high = 1'b1;
    repeat (6) @(negedge clk);
    chk(sw_state == pk(2, 0, 1), "R3 no strobe state", sw_state, pk(2, 0, 1));
    chk(gate == g0, "R3 no strobe gate", gate, g0);
  endtask

  task automatic t_redundant();
    strobe(pk(1, 0, 0), 1'b1, 3'b001);
    chk(sw_state == pk(2, 1, 1), "R6 pos up -> high twin", sw_state, pk(2, 1, 1));
    settle();
    chk(gate == {leg(1), leg(1), leg(2)}, "R6 gate of high twin", gate, {leg(1), leg(1), leg(2)});
    strobe(pk(1, 0, 0), 1'b0, 3'b001);
    chk(sw_state == pk(1, 0, 0), "R6 pos low -> low twin", sw_state, pk(1, 0, 0));
    strobe(pk(2, 1, 1), 1'b1, 3'b000);
    chk(sw_state == pk(1, 0, 0), "R6 neg up -> low twin", sw_state, pk(1, 0, 0));
    strobe(pk(2, 2, 2), 1'b0, 3'b011);
    chk(sw_state == pk(1, 1, 1), "R5 all-two three votes", sw_state, pk(1, 1, 1));
    strobe(pk(1, 1, 1), 1'b1, 3'b111);
    chk(sw_state == pk(2, 2, 2), "R5 all-one three votes", sw_state, pk(2, 2, 2));
    settle();
  endtask

  task automatic t_tie();
    strobe(pk(1, 1, 0), 1'b1, 3'b001);
    chk(sw_state == pk(1, 1, 0), "R5 tie kept", sw_state, pk(1, 1, 0));
    strobe(pk(0, 0, 0), 1'b1, 3'b111);
    chk(sw_state == pk(0, 0, 0), "R5 empty group kept", sw_state, pk(0, 0, 0));
    settle();
  endtask

  task automatic t_dead3();
    dead_cyc = 4'd3;
    strobe(pk(0, 2, 1), 1'b0, 3'b000);
    settle();
    chk(gate[3:0] == 4'b0011, "R7 start leg", gate[3:0], 4'b0011);
    strobe(pk(2, 0, 1), 1'b0, 3'b000);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(gate[3:0] == 4'b0000, "R7 dead gap", gate[3:0], 0);
    end
    @(negedge clk);
    chk(gate[3:0] == 4'b1100, "R7 turn-on after delay", gate[3:0], 4'b1100);
  endtask

  task automatic t_dead0();
    dead_cyc = 4'd0;
    settle();
    strobe(pk(0, 2, 1), 1'b0, 3'b000);
    @(negedge clk);
    chk(gate[3:0] == 4'b0011, "R8 zero delay", gate[3:0], 4'b0011);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_hold();
    t_redundant();
    t_tie();
    t_dead3();
    t_dead0();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule